// File: doc/BRIEF.md
# Fixed Word Recognizer

This block decides, one character at a time, whether a short run of lower-case ASCII characters spells one of seven fixed words: bat, bet, bit, bot, borg, car and cat. A character is taken on every clock edge where the strobe is high. The recognizer tracks which words the characters seen so far could still become. As soon as the outcome is known, it reports it on two registered outputs. `done` marks a decision. `found` tells a match apart from a rejection.

The next state and both outputs fall back to a rejected state on every accepted character. Only the transitions that extend a live prefix, or that complete a word, override that fallback. The output flops are loaded from a decode of the next state, not of the current state. The verdict is therefore visible on the cycle right after the deciding character, with no extra cycle of delay. After any verdict, the next accepted character is the first letter of a fresh word. Idle cycles, where the strobe is low, leave the progress untouched.

Top module: `wordRecognizer`

## Requirements
- R1: While reset is high and on the first cycle after it, `done` and `found` are 0, and the first accepted character after reset is taken as the first letter of a word.
- R2: When an accepted character completes bat, bet, bit, bot, borg, car or cat (ASCII codes 0x61 to 0x7A, lower case), `done` and `found` are both 1 in the cycle right after that clock edge.
- R3: While the accepted characters form a proper prefix of one of the seven words, `done` stays 0, and no character other than a final g, r or t raises `found`.
- R4: An accepted character that does not extend a live prefix gives `done`=1 and `found`=0 in the next cycle.
- R5: On a cycle with `charValid` low, the progress through a word is kept and `done` and `found` are 0 in the next cycle.
- R6: After a verdict (match or rejection), the next accepted character starts a new word, so "cart" reports a match on r and then a rejection on t.
- R7: `found` is never 1 unless `done` is 1 in the same cycle.
- R8: `done` is high for exactly one cycle per verdict. If no character follows, it returns to 0 on the next cycle.
- R9: Matching is case-sensitive. Upper-case letters (0x41 to 0x5A) are rejected like any other stray character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| charValid | input | 1 | Character strobe; `charIn` is taken when high |
| charIn | input | CHAR_W | ASCII character |
| done | output | 1 | Registered verdict pulse |
| found | output | 1 | Registered match flag, qualifies `done` |

## Verification
The corner cases are these:
- Words that share letters: bot against borg, and car against cat. A wrong merge of branches would accept "bor" or "cot".
- A stray letter at every position of every word. A design that fell back to a start state without flagging would leave `done` low here.
- Idle gaps in the middle of a word. A design that applied the rejection default on idle cycles would reject a word that is merely paused.
- Back-to-back words and "cart". These expose a recognizer that keeps searching inside longer text, or one whose verdict lags by a cycle because it decodes the current state.

// File: rtl/wordRecPkg.sv
package wordRecPkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_B, ST_BO, ST_BOR, ST_BV, ST_C, ST_CA,
    ST_HIT_T, ST_HIT_R, ST_HIT_G, ST_FAIL
  } stateT;

  typedef enum logic [3:0] {
    LT_A, LT_B, LT_C, LT_E, LT_G, LT_I, LT_O, LT_R, LT_T, LT_NONE
  } letterT;

  localparam int NUM_LETTERS = 9;

  // ASCII code of the letter with index idx in letterT order
  function automatic logic [7:0] letterAscii(input int idx);
    case (idx)
      0: return 8'h61;  // a
      1: return 8'h62;  // b
      2: return 8'h63;  // c
      3: return 8'h65;  // e
      4: return 8'h67;  // g
      5: return 8'h69;  // i
      6: return 8'h6F;  // o
      7: return 8'h72;  // r
      8: return 8'h74;  // t
      default: return 8'h00;
    endcase
  endfunction

  // strobes from control to datapath
  typedef struct packed {
    logic decide;
    logic hit;
  } strobeT;

endpackage

// File: rtl/wordRecDatapath.sv
module wordRecDatapath
  import wordRecPkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAR_W-1:0] charIn,
  input  strobeT            strobe,
  output letterT            letter,
  output logic              done,
  output logic              found
);

  logic [NUM_LETTERS-1:0] matchVec;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_LETTERS; gi++) begin : g_match
      assign matchVec[gi] = (charIn == CHAR_W'(letterAscii(gi)));
    end
  endgenerate

  always_comb begin
    letter = LT_NONE;
    for (int i = 0; i < NUM_LETTERS; i++) begin
      if (matchVec[i]) letter = letterT'(4'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      found <= 1'b0;
    end else begin
      done  <= strobe.decide;
      found <= strobe.hit;
    end
  end

endmodule

// File: rtl/wordRecControl.sv
module wordRecControl
  import wordRecPkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   charValid,
  input  letterT letter,
  output strobeT strobe
);

  stateT state, nextState;

  always_comb begin
    nextState = state;
    if (charValid) begin
      nextState = ST_FAIL;  // default: reject
      case (state)
        ST_IDLE, ST_HIT_T, ST_HIT_R, ST_HIT_G, ST_FAIL: begin
          if (letter == LT_B)      nextState = ST_B;
          else if (letter == LT_C) nextState = ST_C;
        end
        ST_B: begin
          if (letter == LT_O) nextState = ST_BO;
          else if (letter == LT_A || letter == LT_E || letter == LT_I)
            nextState = ST_BV;
        end
        ST_BO: begin
          if (letter == LT_T)      nextState = ST_HIT_T;
          else if (letter == LT_R) nextState = ST_BOR;
        end
        ST_BOR: if (letter == LT_G) nextState = ST_HIT_G;
        ST_BV:  if (letter == LT_T) nextState = ST_HIT_T;
        ST_C:   if (letter == LT_A) nextState = ST_CA;
        ST_CA: begin
          if (letter == LT_R)      nextState = ST_HIT_R;
          else if (letter == LT_T) nextState = ST_HIT_T;
        end
        default: nextState = ST_FAIL;
      endcase
    end
  end

  // output strobes decoded from the next state
  always_comb begin
    strobe.decide = 1'b0;
    strobe.hit    = 1'b0;
    if (charValid) begin
      case (nextState)
        ST_HIT_T, ST_HIT_R, ST_HIT_G: begin
          strobe.decide = 1'b1;
          strobe.hit    = 1'b1;
        end
        ST_FAIL: strobe.decide = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

endmodule

// File: rtl/wordRecognizer.sv
module wordRecognizer
  import wordRecPkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              charValid,
  input  logic [CHAR_W-1:0] charIn,
  output logic              done,
  output logic              found
);

  strobeT strobe;
  letterT letter;

  wordRecControl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .charValid (charValid),
    .letter    (letter),
    .strobe    (strobe)
  );

  wordRecDatapath #(.CHAR_W(CHAR_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .charIn (charIn),
    .strobe (strobe),
    .letter (letter),
    .done   (done),
    .found  (found)
  );

endmodule

// File: rtl/wordRecognizerChecker.sv
module wordRecognizerChecker #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              charValid,
  input logic [CHAR_W-1:0] charIn,
  input logic              done,
  input logic              found
);

  function automatic logic inWordAlphabet(input logic [CHAR_W-1:0] c);
    return c == CHAR_W'(8'h61) || c == CHAR_W'(8'h62) || c == CHAR_W'(8'h63) ||
           c == CHAR_W'(8'h65) || c == CHAR_W'(8'h67) || c == CHAR_W'(8'h69) ||
           c == CHAR_W'(8'h6F) || c == CHAR_W'(8'h72) || c == CHAR_W'(8'h74);
  endfunction

  function automatic logic isEndLetter(input logic [CHAR_W-1:0] c);
    return c == CHAR_W'(8'h67) || c == CHAR_W'(8'h72) || c == CHAR_W'(8'h74);
  endfunction

  // R7
  a_r7_found_needs_done: assert property (@(posedge clk) disable iff (rst)
    found |-> done);

  // R5
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(charValid) |-> !done);

  // R4
  a_r4_stray_rejects: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(charValid) && !inWordAlphabet($past(charIn)))
      |-> (done && !found));

  // R3
  a_r3_no_early_match: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(charValid) && !isEndLetter($past(charIn))) |-> !found);

  // R2
  a_r2_match_on_final: assert property (@(posedge clk) disable iff (rst)
    found |-> ($past(charValid) && isEndLetter($past(charIn))));

endmodule

bind wordRecognizer wordRecognizerChecker #(.CHAR_W(CHAR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .charValid (charValid),
  .charIn    (charIn),
  .done      (done),
  .found     (found)
);

// File: tb/wordRecognizer_tb.sv
module wordRecognizer_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       charValid = 1'b0;
  logic [7:0] charIn = 8'h00;
  logic       done;
  logic       found;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #2ns clk = ~clk;  // 250 MHz

  wordRecognizer u_dut (
    .clk       (clk),
    .rst       (rst),
    .charValid (charValid),
    .charIn    (charIn),
    .done      (done),
    .found     (found)
  );

  string words[7] = '{"borg", "car", "cat", "bat", "bot", "bet", "bit"};

  // reference model state
  string acc = "";
  logic  expDone = 0;
  logic  expFound = 0;
  string expTag = "R1";

  function automatic bit isWord(string s);
    foreach (words[i]) if (words[i] == s) return 1;
    return 0;
  endfunction

  function automatic bit isPrefix(string s);
    foreach (words[i])
      if (words[i].len() > s.len() && words[i].substr(0, s.len() - 1) == s) return 1;
    return 0;
  endfunction

  task automatic compare();
    vectors++;
    if (done !== expDone || found !== expFound) begin
      miscompares++;
      $display("FAIL %s: done=%b found=%b expected done=%b found=%b",
               expTag, done, found, expDone, expFound);
    end
  endtask

  // one cycle: check the previous cycle's result, then drive the next input
  task automatic step(input logic v, input byte c);
    string cand;
    bit    afterVerdict;
    @(negedge clk);
    compare();
    afterVerdict = expDone;
    if (rst) begin
      expDone = 0; expFound = 0; expTag = "R1";
    end else if (!v) begin
      expTag = expDone ? "R8" : "R5";
      expDone = 0; expFound = 0;
    end else begin
      cand = {acc, " "};
      cand.putc(cand.len() - 1, c);
      if (isWord(cand)) begin
        expDone = 1; expFound = 1; expTag = "R2"; acc = "";
      end else if (isPrefix(cand)) begin
        expDone = 0; expFound = 0; expTag = afterVerdict ? "R6" : "R3"; acc = cand;
      end else begin
        expDone = 1; expFound = 0; acc = "";
        expTag = (c >= 8'h41 && c <= 8'h5A) ? "R9" : "R4";
      end
    end
    charValid = v;
    charIn = c;
  endtask

  task automatic sendStr(string s, int gap);
    for (int i = 0; i < s.len(); i++) begin
      step(1'b1, s[i]);
      for (int g = 0; g < gap; g++) step(1'b0, 8'h00);
    end
  endtask

  initial begin
    // R1: outputs low in and right after reset
    for (int i = 0; i < 3; i++) step(1'b0, 8'h00);
    rst = 1'b0;
    step(1'b0, 8'h00);
    // R1/R2: first word right after reset
    sendStr("car", 0);
    step(1'b0, 8'h00);  // R8: pulse ends
    // R2: every word, separated by idle
    foreach (words[i]) begin
      sendStr(words[i], 0);
      step(1'b0, 8'h00);
    end
    // R2/R6: words back to back
    foreach (words[i]) sendStr(words[i], 0);
    // R5: idle gaps inside words
    sendStr("borg", 2);
    sendStr("bet", 1);
    // R3/R4: each proper prefix followed by a stray letter, at every position
    foreach (words[i]) begin
      for (int p = 0; p < words[i].len(); p++) begin
        if (p > 0) sendStr(words[i].substr(0, p - 1), 0);
        sendStr("x", 0);
        step(1'b0, 8'h00);
      end
    end
    // R4: letters in the alphabet but in the wrong place
    sendStr("cot", 0);
    sendStr("bor", 0); sendStr("t", 0);
    sendStr("bb", 0);
    sendStr("bog", 0);
    sendStr("cag", 0);
    // R6: no search inside longer text
    sendStr("cart", 0);
    sendStr("borgt", 0);
    sendStr("xbat", 0);
    // R9: case-sensitive
    sendStr("CAR", 0);
    sendStr("bAt", 0);
    step(1'b0, 8'h00);
    step(1'b0, 8'h00);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule